// File: doc/BRIEF.md
# Channel Packet Formatter

The formatter turns a stream of words held in per-channel buffers into framed packets for a downstream receiver. It first asks an arbiter which channel to serve and captures the returned channel index. It then decodes that channel's 2-bit length code into a packet size of 4, 8, 16 or 32 words and waits until the chosen buffer holds a whole packet. After that it requests the downstream link, and once the grant arrives it streams the packet on back-to-back cycles.

Each buffer shows its fill level and its head word, which is visible before it is popped. The formatter pops the chosen buffer once for each word it sends. The channel index and the packet length are presented with the request and are held until the last word. Start and end strobes mark the first and last words of the packet. The formatter then goes back to asking the arbiter for the next channel.

Top module: `pkt_formatter`

## Requirements
- R1: While reset is low, `id_req`, `pkt_req`, `pkt_valid`, `pkt_sop`, `pkt_eop` and `ch_pop` are all 0. On the first clock edge after reset is released, the block starts asking the arbiter, so `id_req` is 1 in the first cycle after release.
- R2: `id_req` stays high until a cycle in which `id_valid` is 1 and `id_sel` is below the channel count (0, 1 or 2). In that cycle the channel index is captured and `id_req` drops on the next edge. An `id_sel` of 3 is ignored and `id_req` stays high.
- R3: The packet length is 4 shifted left by the captured channel's 2-bit length code: code 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. The code is sampled in the cycle the channel index is accepted.
- R4: `pkt_req` does not rise until the fill level of the chosen channel is at least the packet length. A fill level exactly equal to the length is enough.
- R5: `pkt_req` stays high until `pkt_gnt` is seen. It drops in the cycle that carries the first word, which is the cycle after the grant.
- R6: Once granted, the block sends exactly one packet length of words on consecutive cycles with `pkt_valid` high. The words come from the chosen channel's head word, in buffer order. `ch_pop` pulses only that channel's bit, once per word, and any words beyond the packet stay in the buffer.
- R7: `pkt_sop` is 1 only with the first word and `pkt_eop` only with the last word, each for one cycle. For a 4-word packet the end strobe comes three cycles after the start strobe.
- R8: `pkt_ch` and `pkt_len` hold their values from the rise of `pkt_req` until the end strobe, even if the length code input changes in that time.
- R9: In the cycle after the end strobe, `pkt_valid` is 0 and `id_req` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_len_code | input | NUM_CH*2 | Per-channel length code, channel c at bits [2c+1:2c] |
| ch_fill | input | NUM_CH*FILL_W | Per-channel buffer fill level |
| ch_word | input | NUM_CH*DATA_W | Per-channel head word, visible before pop |
| ch_pop | output | NUM_CH | Pop strobe, one bit per channel |
| id_req | output | 1 | Asks the arbiter for the next channel |
| id_valid | input | 1 | Arbiter answer valid |
| id_sel | input | CH_W | Channel index chosen by the arbiter |
| pkt_req | output | 1 | Downstream request |
| pkt_gnt | input | 1 | Downstream grant |
| pkt_valid | output | 1 | A packet word is on `pkt_data` |
| pkt_sop | output | 1 | First word of the packet |
| pkt_eop | output | 1 | Last word of the packet |
| pkt_ch | output | CH_W | Channel of the current packet |
| pkt_len | output | LEN_W | Length of the current packet in words |
| pkt_data | output | DATA_W | Packet word |

## Verification
The hardest case to reach is a packet whose chosen channel is short of words when it is chosen. The bench sets this up by keeping the buffer too shallow after the arbiter answers. It then watches `pkt_req` stay low for several cycles and tops up the buffer, which must bring the request out. A second case changes the length code while a request is waiting for its grant, so the bench can confirm that the length and channel already captured hold. A third case leaves more words in a buffer than one packet needs and runs two packets from it in a row. This shows that only one packet's worth of words is taken each time and that buffer order carries across the packet boundary.

// File: rtl/pf_pkg.sv
package pf_pkg;

    // width of one length code per channel
    localparam int unsigned LEN_CODE_W = 2;
    // smallest packet the formatter produces
    localparam int unsigned BASE_LEN   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_FILL,
        ST_REQ,
        ST_SEND
    } pf_state_e;

endpackage

// File: rtl/pf_len_decode.sv
module pf_len_decode
    import pf_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned LEN_W  = 6
) (
    input  logic [NUM_CH*LEN_CODE_W-1:0] codes,
    output logic [NUM_CH*LEN_W-1:0]      lens
);

    // one decoder per channel: length = BASE_LEN << code
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        logic [LEN_CODE_W-1:0] code_c;
        assign code_c = codes[c*LEN_CODE_W +: LEN_CODE_W];
        assign lens[c*LEN_W +: LEN_W] = LEN_W'(BASE_LEN) << code_c;
    end

endmodule

// File: rtl/pf_ch_select.sv
module pf_ch_select #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FILL_W = 6,
    parameter int unsigned CH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CH_W-1:0]          sel,
    input  logic                     pop_en,
    input  logic [NUM_CH*FILL_W-1:0] fill_bus,
    input  logic [NUM_CH*DATA_W-1:0] word_bus,
    output logic [FILL_W-1:0]        sel_fill,
    output logic [DATA_W-1:0]        sel_word,
    output logic [NUM_CH-1:0]        pop
);

    // pop strobe decoded per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pop
        assign pop[c] = pop_en && (sel == CH_W'(c));
    end

    // fill level and head word of the selected channel
    always_comb begin
        sel_fill = '0;
        sel_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel == CH_W'(c)) begin
                sel_fill = fill_bus[c*FILL_W +: FILL_W];
                sel_word = word_bus[c*DATA_W +: DATA_W];
            end
        end
    end

    // a pop must never hit an empty buffer
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (sel_fill != '0));

    // at most one channel popped per cycle
    assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned FILL_W = 6,
    parameter int unsigned LEN_W  = 6,
    parameter int unsigned CH_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*LEN_W-1:0] lens,
    input  logic                    id_valid,
    input  logic [CH_W-1:0]         id_sel,
    input  logic [FILL_W-1:0]       sel_fill,
    input  logic                    pkt_gnt,
    output logic                    id_req,
    output logic                    pkt_req,
    output logic                    send,
    output logic                    pkt_sop,
    output logic                    pkt_eop,
    output logic [CH_W-1:0]         pkt_ch,
    output logic [LEN_W-1:0]        pkt_len
);

    localparam int unsigned CMP_W = (FILL_W > LEN_W) ? FILL_W : LEN_W;

    typedef struct packed {
        pf_state_e         state;
        logic [CH_W-1:0]   ch;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             id_ok;
    logic [LEN_W-1:0] len_pick;
    logic             fill_ok;
    logic             last_word;

    // length of the channel named by the arbiter; out-of-range ids are rejected
    always_comb begin
        id_ok    = 1'b0;
        len_pick = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (id_sel == CH_W'(c)) begin
                id_ok    = 1'b1;
                len_pick = lens[c*LEN_W +: LEN_W];
            end
        end
    end

    assign fill_ok   = CMP_W'(sel_fill) >= CMP_W'(ctl_q.len);
    assign last_word = (ctl_q.cnt == ctl_q.len - LEN_W'(1));

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: ctl_d.state = ST_ASK;
            ST_ASK: begin
                if (id_valid && id_ok) begin
                    ctl_d.ch    = id_sel;
                    ctl_d.len   = len_pick;
                    ctl_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (fill_ok) ctl_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (pkt_gnt) begin
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                ctl_d.cnt = ctl_q.cnt + LEN_W'(1);
                if (last_word) ctl_d.state = ST_ASK;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.ch    <= '0;
            ctl_q.len   <= '0;
            ctl_q.cnt   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign id_req  = (ctl_q.state == ST_ASK);
    assign pkt_req = (ctl_q.state == ST_REQ);
    assign send    = (ctl_q.state == ST_SEND);
    assign pkt_sop = send && (ctl_q.cnt == '0);
    assign pkt_eop = send && last_word;
    assign pkt_ch  = ctl_q.ch;
    assign pkt_len = ctl_q.len;

    // only the four legal lengths are ever presented
    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req || send) |-> (pkt_len == LEN_W'(4) || pkt_len == LEN_W'(8) ||
                               pkt_len == LEN_W'(16) || pkt_len == LEN_W'(32)));

    // the request only rises once a full packet is buffered
    assert_req_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_req) |-> (CMP_W'(sel_fill) >= CMP_W'(pkt_len)));

    // request held until granted
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && !pkt_gnt) |=> pkt_req);

    // first word follows a seen grant
    assert_sop_after_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_gnt) |=> (send && pkt_sop && !pkt_req));

    // start and end strobes are single-cycle
    assert_sop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sop |=> !pkt_sop);
    assert_eop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_eop |=> (!pkt_eop && !send));

    // channel and length frozen from request to end strobe
    assert_hdr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req || (send && !pkt_eop)) |=> ($stable(pkt_ch) && $stable(pkt_len)));

    // back to asking the arbiter after a packet
    assert_reask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_eop |=> id_req);

endmodule

// File: rtl/pkt_formatter.sv
module pkt_formatter
    import pf_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FILL_W = 6,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned LEN_W = $clog2((BASE_LEN << ((1 << LEN_CODE_W) - 1)) + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH*LEN_CODE_W-1:0] ch_len_code,
    input  logic [NUM_CH*FILL_W-1:0]     ch_fill,
    input  logic [NUM_CH*DATA_W-1:0]     ch_word,
    output logic [NUM_CH-1:0]            ch_pop,
    output logic                         id_req,
    input  logic                         id_valid,
    input  logic [CH_W-1:0]              id_sel,
    output logic                         pkt_req,
    input  logic                         pkt_gnt,
    output logic                         pkt_valid,
    output logic                         pkt_sop,
    output logic                         pkt_eop,
    output logic [CH_W-1:0]              pkt_ch,
    output logic [LEN_W-1:0]             pkt_len,
    output logic [DATA_W-1:0]            pkt_data
);

    logic [NUM_CH*LEN_W-1:0] lens;
    logic [FILL_W-1:0]       sel_fill;
    logic                    send;

    pf_len_decode #(
        .NUM_CH (NUM_CH),
        .LEN_W  (LEN_W)
    ) u_len_decode (
        .codes  (ch_len_code),
        .lens   (lens)
    );

    pf_ch_select #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .FILL_W   (FILL_W),
        .CH_W     (CH_W)
    ) u_ch_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (pkt_ch),
        .pop_en   (send),
        .fill_bus (ch_fill),
        .word_bus (ch_word),
        .sel_fill (sel_fill),
        .sel_word (pkt_data),
        .pop      (ch_pop)
    );

    pf_ctrl #(
        .NUM_CH   (NUM_CH),
        .FILL_W   (FILL_W),
        .LEN_W    (LEN_W),
        .CH_W     (CH_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lens     (lens),
        .id_valid (id_valid),
        .id_sel   (id_sel),
        .sel_fill (sel_fill),
        .pkt_gnt  (pkt_gnt),
        .id_req   (id_req),
        .pkt_req  (pkt_req),
        .send     (send),
        .pkt_sop  (pkt_sop),
        .pkt_eop  (pkt_eop),
        .pkt_ch   (pkt_ch),
        .pkt_len  (pkt_len)
    );

    assign pkt_valid = send;

    // outputs quiet whenever nothing is being sent (R1, R6)
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> (!pkt_sop && !pkt_eop && (ch_pop == '0)));

endmodule

// File: tb/test_pkt_formatter.sv
module test_pkt_formatter;

    localparam int NUM_CH = 3;
    localparam int DATA_W = 32;
    localparam int FILL_W = 6;
    localparam int CH_W   = 2;
    localparam int LEN_W  = 6;
    localparam int DEPTH  = 128;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic [NUM_CH*2-1:0]      ch_len_code = '0;
    logic [NUM_CH*FILL_W-1:0] ch_fill = '0;
    logic [NUM_CH*DATA_W-1:0] ch_word = '0;
    logic [NUM_CH-1:0]        ch_pop;
    logic                     id_req;
    logic                     id_valid = 1'b0;
    logic [CH_W-1:0]          id_sel = '0;
    logic                     pkt_req;
    logic                     pkt_gnt = 1'b0;
    logic                     pkt_valid, pkt_sop, pkt_eop;
    logic [CH_W-1:0]          pkt_ch;
    logic [LEN_W-1:0]         pkt_len;
    logic [DATA_W-1:0]        pkt_data;

    pkt_formatter #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .FILL_W(FILL_W)) i_pkt_formatter (
        .clk(clk), .rst_n(rst_n), .ch_len_code(ch_len_code), .ch_fill(ch_fill),
        .ch_word(ch_word), .ch_pop(ch_pop), .id_req(id_req), .id_valid(id_valid),
        .id_sel(id_sel), .pkt_req(pkt_req), .pkt_gnt(pkt_gnt), .pkt_valid(pkt_valid),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_ch(pkt_ch), .pkt_len(pkt_len),
        .pkt_data(pkt_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int wr_p  [NUM_CH];
    int rd_p  [NUM_CH];
    int exp_n [NUM_CH];
    logic [1:0] codes [NUM_CH];
    logic [DATA_W-1:0] mem [NUM_CH][DEPTH];
    logic [NUM_CH-1:0] pend_pop = '0;

    function automatic logic [DATA_W-1:0] word_of(input int c, input int n);
        return 32'hC000_0000 + (c << 24) + n;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic refresh();
        for (int c = 0; c < NUM_CH; c++) begin
            int lvl = wr_p[c] - rd_p[c];
            if (lvl > 63) lvl = 63;
            ch_fill[c*FILL_W +: FILL_W] = FILL_W'(lvl);
            ch_word[c*DATA_W +: DATA_W] = mem[c][rd_p[c] % DEPTH];
            ch_len_code[c*2 +: 2]       = codes[c];
        end
    endtask

    task automatic push(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            mem[c][wr_p[c] % DEPTH] = word_of(c, wr_p[c]);
            wr_p[c]++;
        end
        refresh();
    endtask

    // one cycle: advance at falling edge, apply pops of the elapsed cycle, settle
    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) if (pend_pop[c]) rd_p[c]++;
        refresh();
        #1;
        pend_pop = ch_pop;
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
    endtask

    // one full packet through the handshakes; caller leaves block in ask state
    task automatic run_packet(input int c, input int gdly, input bit starve, input bit recode);
        int len = 4 << codes[c];
        chk("R9 id_req before answer", 32'(id_req), 1);
        id_valid = 1'b1;
        id_sel   = CH_W'(c);
        tick();
        id_valid = 1'b0;
        chk("R2 id_req drops after accept", 32'(id_req), 0);
        if (starve) begin
            for (int k = 0; k < 3; k++) begin
                tick();
                chk("R4 no request while short", 32'(pkt_req), 0);
            end
            push(c, len - (wr_p[c] - rd_p[c]));
        end
        for (int k = 0; k < 10 && !pkt_req; k++) tick();
        chk("R5 request raised", 32'(pkt_req), 1);
        chk("R3 length", 32'(pkt_len), 32'(len));
        chk("R8 channel", 32'(pkt_ch), 32'(c));
        if (recode) begin
            codes[c] = codes[c] + 2'd1;
            refresh();
        end
        for (int d = 0; d < gdly; d++) begin
            tick();
            chk("R5 request held", 32'(pkt_req), 1);
            chk("R8 length held", 32'(pkt_len), 32'(len));
        end
        pkt_gnt = 1'b1;
        tick();
        pkt_gnt = 1'b0;
        chk("R5 request dropped with first word", 32'(pkt_req), 0);
        for (int i = 0; i < len; i++) begin
            chk("R6 valid", 32'(pkt_valid), 1);
            chk("R6 data", pkt_data, word_of(c, exp_n[c]));
            chk("R6 pop", 32'(ch_pop), 32'(1 << c));
            chk("R7 sop", 32'(pkt_sop), 32'(i == 0));
            chk("R7 eop", 32'(pkt_eop), 32'(i == len - 1));
            chk("R8 channel held", 32'(pkt_ch), 32'(c));
            chk("R8 length held", 32'(pkt_len), 32'(len));
            exp_n[c]++;
            tick();
        end
        chk("R9 valid low after end", 32'(pkt_valid), 0);
        chk("R9 id_req back", 32'(id_req), 1);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R1 id_req in reset", 32'(id_req), 0);
            chk("R1 pkt_req in reset", 32'(pkt_req), 0);
            chk("R1 valid in reset", 32'(pkt_valid), 0);
            chk("R1 strobes in reset", 32'({pkt_sop, pkt_eop}), 0);
            chk("R1 pop in reset", 32'(ch_pop), 0);
        end
        rst_n = 1'b1;
        tick();
        chk("R1 id_req after release", 32'(id_req), 1);
    endtask

    task automatic t_bad_id();
        id_valid = 1'b1;
        id_sel   = 2'd3;
        tick();
        id_valid = 1'b0;
        chk("R2 bad id ignored", 32'(id_req), 1);
        tick();
        chk("R2 still asking", 32'(id_req), 1);
    endtask

    task automatic t_short_exact();
        codes[0] = 2'd0;
        push(0, 4);
        run_packet(0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_starve();
        codes[1] = 2'd1;
        push(1, 2);
        run_packet(1, 3, 1'b1, 1'b0);
    endtask

    task automatic t_long_recode();
        codes[2] = 2'd3;
        push(2, 32);
        run_packet(2, 2, 1'b0, 1'b1);
    endtask

    task automatic t_sixteen();
        codes[0] = 2'd2;
        push(0, 16);
        run_packet(0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_surplus();
        codes[1] = 2'd0;
        push(1, 10);
        run_packet(1, 1, 1'b0, 1'b0);
        chk("R6 surplus words left", 32'(wr_p[1] - rd_p[1]), 6);
        run_packet(1, 2, 1'b0, 1'b0);
        chk("R6 surplus after second", 32'(wr_p[1] - rd_p[1]), 2);
    endtask

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_p[c] = 0; rd_p[c] = 0; exp_n[c] = 0; codes[c] = 2'd0;
            for (int j = 0; j < DEPTH; j++) mem[c][j] = '0;
        end
        refresh();
        t_reset();
        t_bad_id();
        t_short_exact();
        t_starve();
        t_long_recode();
        t_sixteen();
        t_surplus();
        summary();
    end

endmodule